// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for each beat of a read or write burst inside an already open row. A start strobe captures a 9-bit starting column together with the burst length code and the wrap-order bit from the mode-register image. From the next clock the block emits one column per cycle with a valid flag and marks the final beat with a last flag.

Fixed-length bursts wrap inside an aligned group of 2, 4 or 8 columns. The order inside the group is either a sequential count or an interleaved pattern. Full-page bursts walk the whole 512-column row and keep going until they are cut. A terminate input stands for a burst-stop or precharge and ends the burst early. A fresh start on any cycle drops the running burst and begins again at the new column. The memory command sequencing and the data path are handled elsewhere.

Top module: `burstColGen`

## Requirements
- R1: After reset, and until the first start, `colValid` and `colLast` are 0.
- R2: When `startValid` is 1 at a rising edge, `colValid` is 1 from that edge on and `colAddr` equals the captured `startCol`. A start on each of several consecutive cycles makes each of those columns appear once, in order.
- R3: `modeBl` codes 1, 2 and 3 select burst lengths 2, 4 and 8. With `modeInterleave` = 0, beat k carries the start's upper bits unchanged. Its low log2(length) bits are the start's low bits plus k, modulo the length.
- R4: With `modeInterleave` = 1 and `modeBl` code 1, 2 or 3, the low log2(length) bits of beat k are the start's low bits XOR k, and the upper bits are unchanged.
- R5: `colLast` is 1 only on the final beat of a fixed-length burst. On the cycle after that beat `colValid` is 0, unless a new start was sampled.
- R6: `modeBl` code 0 gives a single beat, on which `colLast` is 1. The reserved codes 4, 5 and 6 behave the same way.
- R7: `modeBl` code 7 selects full page. The column starts at the start column, increases by 1 each cycle and wraps from 511 to 0. `colLast` is never set, and the burst continues until it is terminated or restarted.
- R8: When `terminate` is 1 at a rising edge and `startValid` is 0, `colValid` is 0 from that edge on. If both are 1, the start takes effect.
- R9: A start sampled during a running burst replaces it. From that edge the new burst's sequence is emitted from beat 0.
- R10: `modeInterleave` has no effect for full page or for single-beat codes. Those bursts follow R7 and R6.
- R11: `modeBl` and `modeInterleave` are sampled only with a start. Changing them during a burst does not alter that burst's columns or length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| startValid | input | 1 | Begin a burst at `startCol` |
| startCol | input | 9 | Starting column |
| modeBl | input | 3 | Burst length code (0:1, 1:2, 2:4, 3:8, 7:full page) |
| modeInterleave | input | 1 | Wrap order, 1 selects interleaved |
| terminate | input | 1 | Burst-stop or precharge, ends the burst |
| colValid | output | 1 | A column is emitted this cycle |
| colAddr | output | 9 | Column for the current beat |
| colLast | output | 1 | Current beat is the final one |

## Verification
The hardest cases are the collisions at the end of a burst. These are a restart on the exact cycle the last beat is shown, a terminate on the same edge as a start, and a full-page wrap across column 511. Each needs a start placed on one chosen cycle relative to a running sequence. The stimulus is driven one cycle at a time by a reference stepper in the bench, so a scenario can place a start or terminate on any beat. A full-page burst is started two columns below the row end so that the wrap appears within a few beats.

// File: rtl/burstColPkg.sv
package burstColPkg;

  // Burst length codes of the mode image
  localparam logic [2:0] BlOne  = 3'd0;
  localparam logic [2:0] BlTwo  = 3'd1;
  localparam logic [2:0] BlFour = 3'd2;
  localparam logic [2:0] BlEight = 3'd3;
  localparam logic [2:0] BlPage = 3'd7;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;
    logic advance;
  } ctlStrobe_t;

endpackage

// File: rtl/burstColPath.sv
module burstColPath
  import burstColPkg::*;
#(
  parameter int ColW = 9
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctlStrobe_t      strobe,
  input  logic [ColW-1:0] startCol,
  input  logic [2:0]      modeBl,
  input  logic            modeInterleave,
  output logic [ColW-1:0] colAddr,
  output logic            beatFinal
);

  localparam logic [ColW-1:0] AllOnes = '1;

  logic [ColW-1:0] baseCol;
  logic [ColW-1:0] beatCnt;
  logic [ColW-1:0] wrapMask;
  logic            useXor;
  logic            fullPage;

  logic [ColW-1:0] maskNext;
  logic            pageNext;

  // Decode the wrap window for the captured length
  always_comb begin
    pageNext = 1'b0;
    unique case (modeBl)
      BlTwo:   maskNext = ColW'(1);
      BlFour:  maskNext = ColW'(3);
      BlEight: maskNext = ColW'(7);
      BlPage: begin
        maskNext = AllOnes;
        pageNext = 1'b1;
      end
      default: maskNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseCol  <= '0;
      beatCnt  <= '0;
      wrapMask <= '0;
      useXor   <= 1'b0;
      fullPage <= 1'b0;
    end else if (strobe.load) begin
      baseCol  <= startCol;
      beatCnt  <= '0;
      wrapMask <= maskNext;
      fullPage <= pageNext;
      useXor   <= modeInterleave && !pageNext && (maskNext != '0);
    end else if (strobe.advance) begin
      beatCnt <= beatCnt + ColW'(1);
    end
  end

  logic [ColW-1:0] lowSeq;
  logic [ColW-1:0] lowXor;

  always_comb begin
    lowSeq  = baseCol + beatCnt;
    lowXor  = baseCol ^ beatCnt;
    colAddr = (baseCol & ~wrapMask) | ((useXor ? lowXor : lowSeq) & wrapMask);
  end

  assign beatFinal = !fullPage && (beatCnt == wrapMask);

endmodule

// File: rtl/burstColCtl.sv
module burstColCtl
  import burstColPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startValid,
  input  logic       terminate,
  input  logic       beatFinal,
  output ctlStrobe_t strobe,
  output logic       colValid,
  output logic       colLast
);

  logic active;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
    end else if (startValid) begin
      active <= 1'b1;
    end else if (terminate || beatFinal) begin
      active <= 1'b0;
    end
  end

  always_comb begin
    strobe.load    = startValid;
    strobe.advance = active && !terminate;
  end

  assign colValid = active;
  assign colLast  = active && beatFinal;

endmodule

// File: rtl/burstColGen.sv
module burstColGen
  import burstColPkg::*;
#(
  parameter int ColW = 9
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            startValid,
  input  logic [ColW-1:0] startCol,
  input  logic [2:0]      modeBl,
  input  logic            modeInterleave,
  input  logic            terminate,
  output logic            colValid,
  output logic [ColW-1:0] colAddr,
  output logic            colLast
);

  ctlStrobe_t strobe;
  logic       beatFinal;

  burstColCtl u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .startValid(startValid),
    .terminate (terminate),
    .beatFinal (beatFinal),
    .strobe    (strobe),
    .colValid  (colValid),
    .colLast   (colLast)
  );

  burstColPath #(.ColW(ColW)) u_path (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .startCol      (startCol),
    .modeBl        (modeBl),
    .modeInterleave(modeInterleave),
    .colAddr       (colAddr),
    .beatFinal     (beatFinal)
  );

endmodule

// File: rtl/burstColChk.sv
module burstColChk #(
  parameter int ColW = 9
) (
  input logic            clk,
  input logic            rstN,
  input logic            startValid,
  input logic [ColW-1:0] startCol,
  input logic            terminate,
  input logic            colValid,
  input logic [ColW-1:0] colAddr,
  input logic            colLast
);

  a_r5_last_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    colLast |-> colValid);

  a_r2_start_loads_col: assert property (@(posedge clk) disable iff (!rstN)
    startValid |=> (colValid && colAddr == $past(startCol)));

  a_r8_terminate_stops: assert property (@(posedge clk) disable iff (!rstN)
    (terminate && !startValid) |=> !colValid);

  a_r5_idle_after_last: assert property (@(posedge clk) disable iff (!rstN)
    (colLast && !startValid && !terminate) |=> !colValid);

  a_r3_beat_moves: assert property (@(posedge clk) disable iff (!rstN)
    (colValid && !colLast && !startValid && !terminate) |=> (colValid && colAddr != $past(colAddr)));

endmodule

bind burstColGen burstColChk #(.ColW(ColW)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .startValid(startValid),
  .startCol  (startCol),
  .terminate (terminate),
  .colValid  (colValid),
  .colAddr   (colAddr),
  .colLast   (colLast)
);

// File: tb/tb_burstColGen.sv
module tb_burstColGen;

  localparam int ClkPeriod = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startValid = 1'b0;
  logic [8:0] startCol = '0;
  logic [2:0] modeBl = '0;
  logic       modeInterleave = 1'b0;
  logic       terminate = 1'b0;
  logic       colValid;
  logic [8:0] colAddr;
  logic       colLast;

  always #(ClkPeriod/2) clk = ~clk;

  burstColGen dut (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startCol(startCol),
    .modeBl(modeBl), .modeInterleave(modeInterleave), .terminate(terminate),
    .colValid(colValid), .colAddr(colAddr), .colLast(colLast)
  );

  typedef struct {
    bit       valid;
    bit [8:0] col;
    bit       last;
    string    tag;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int fails = 0;
  bit done = 0;

  // Reference stepper state (from the requirements)
  bit       mActive = 0;
  bit [8:0] mBase, mBeat, mMask;
  bit       mXor, mPage;

  function automatic bit [8:0] maskOf(bit [2:0] code);
    case (code)
      3'd1: return 9'd1;
      3'd2: return 9'd3;
      3'd3: return 9'd7;
      3'd7: return 9'h1FF;
      default: return 9'd0;
    endcase
  endfunction

  function automatic bit [8:0] expCol();
    bit [8:0] low;
    low = mXor ? (mBase ^ mBeat) : (mBase + mBeat);
    return (mBase & ~mMask) | (low & mMask);
  endfunction

  // Driver: apply one cycle of inputs and push the expected result
  task automatic step(bit st, bit [8:0] c, bit [2:0] code, bit ilv, bit term, string tag);
    expItem_t it;
    bit wasFinal;
    @(negedge clk);
    startValid = st; startCol = c; modeBl = code; modeInterleave = ilv; terminate = term;
    wasFinal = mActive && !mPage && (mBeat == mMask);
    if (st) begin
      mActive = 1; mBase = c; mBeat = 0; mMask = maskOf(code);
      mPage = (code == 3'd7);
      mXor = ilv && (code >= 3'd1 && code <= 3'd3);
    end else if (term || wasFinal) begin
      mActive = 0;
    end else if (mActive) begin
      mBeat = mBeat + 9'd1;
    end
    it.valid = mActive;
    it.col = mActive ? expCol() : 9'd0;
    it.last = mActive && !mPage && (mBeat == mMask);
    it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(0, 9'h0AA, 3'd5, 1, 0, tag);
  endtask

  task automatic burst(bit [8:0] c, bit [2:0] code, bit ilv, int n, string tag);
    step(1, c, code, ilv, 0, tag);
    for (int i = 1; i < n; i++) step(0, 9'h155, code, ilv, 0, tag);
  endtask

  // Monitor: compare each cycle after the edge settles
  initial begin
    expItem_t e;
    forever begin
      @(posedge clk);
      #(ClkPeriod/4);
      if (expQ.size() > 0) begin
        e = expQ.pop_front();
        checks++;
        if (colValid !== e.valid || colLast !== e.last || (e.valid && colAddr !== e.col)) begin
          fails++;
          $display("FAIL %s: got valid=%0b col=%03h last=%0b, expected valid=%0b col=%03h last=%0b",
                   e.tag, colValid, colAddr, colLast, e.valid, e.col, e.last);
        end
      end
    end
  end

  initial begin
    #(ClkPeriod * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got running, expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (colValid !== 1'b0 || colLast !== 1'b0) begin
      fails++;
      $display("FAIL R1: got valid=%0b last=%0b, expected 0 0", colValid, colLast);
    end
    rstN = 1'b1;
    idle(2, "R1");
    burst(9'h1F5, 3'd3, 0, 10, "R3 seq len8");
    burst(9'h0A3, 3'd2, 0, 6, "R3 seq len4");
    burst(9'h031, 3'd1, 0, 3, "R3 seq len2");
    burst(9'h0C6, 3'd3, 1, 9, "R4 ilv len8");
    burst(9'h10D, 3'd2, 1, 5, "R4 ilv len4");
    burst(9'h07B, 3'd0, 0, 2, "R6 len1");
    burst(9'h07C, 3'd5, 1, 2, "R6 reserved code");
    burst(9'h1FE, 3'd7, 0, 8, "R7 full page wrap");
    step(0, 9'h0, 3'd7, 0, 1, "R8 terminate page");
    idle(1, "R8");
    burst(9'h1FD, 3'd7, 1, 5, "R10 ilv ignored page");
    step(0, 9'h0, 3'd7, 0, 1, "R10 terminate");
    burst(9'h044, 3'd3, 0, 3, "R8 mid len8");
    step(0, 9'h0, 3'd3, 0, 1, "R8 terminate mid");
    idle(1, "R8");
    burst(9'h050, 3'd3, 0, 2, "R8 before collide");
    step(1, 9'h123, 3'd2, 1, 1, "R8 start beats terminate");
    idle(5, "R8 after collide");
    burst(9'h060, 3'd3, 0, 3, "R9 before restart");
    burst(9'h0E9, 3'd2, 0, 6, "R9 restart");
    burst(9'h0F2, 3'd1, 0, 2, "R9 start at last");
    burst(9'h0F8, 3'd1, 0, 3, "R9 restart on last beat");
    step(1, 9'h011, 3'd0, 0, 0, "R2 back to back");
    step(1, 9'h022, 3'd0, 0, 0, "R2 back to back");
    step(1, 9'h033, 3'd3, 1, 0, "R2 back to back");
    step(0, 9'h0, 3'd7, 0, 0, "R11 mode change");
    step(0, 9'h0, 3'd0, 0, 0, "R11 mode change");
    for (int i = 0; i < 7; i++) step(0, 9'h0, 3'd7, 0, 0, "R11 mode change R5");
    idle(2, "R5 idle");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule